// File: doc/BRIEF.md
# Oscilloscope Sweep Mode Controller

This synchronous controller decides when a timebase sweep may begin. It has three run modes. In normal mode only a trigger starts a sweep. In auto mode the sweep free-runs after a programmable quiet period with no trigger, so a baseline stays visible. In single-shot mode one sweep runs and the controller then locks until the operator presses the re-arm button. After every sweep, and whenever the host raises its lockout line, a programmable holdoff interval keeps the sweep inhibited while the ramp recovers. All timing is counted in clock cycles.

The controller is a four-state machine with these states:

- `ST_ARMED`: waiting for a trigger, with `ready` high.
- `ST_SWEEP`: a sweep is running.
- `ST_HOLDOFF`: the recovery interval is being counted down.
- `ST_LOCKED`: single-shot mode after its one sweep, waiting for re-arm.

The transitions are:

- ARMED→SWEEP on a start, which is a trigger or an auto timeout.
- ARMED→HOLDOFF, SWEEP→HOLDOFF and LOCKED→HOLDOFF on lockout.
- SWEEP→HOLDOFF on end of sweep.
- HOLDOFF→ARMED, or HOLDOFF→LOCKED when a single shot has been spent, once the count is zero and lockout is low.
- LOCKED→ARMED on re-arm.
- Any state→ARMED or LOCKED on a change of `mode_sel`.

`sweep_start`, `auto_req` and `ready` are combinational in the current cycle. The state, the mode register and both counters update on the rising clock edge.

Top module: `sweep_mode_ctrl`

## Requirements
- R1: After reset, with `mode_sel`=0, the controller is in ARMED in normal mode: `ready`=1 and `sweep_inhibit`, `holdoff_active`, `sweep_start` and `auto_req` are all 0.
- R2: In ARMED, a cycle with `trig_in`=1, no lockout and no mode change raises `sweep_start` in that same cycle. The following cycle is SWEEP, with `ready`=0 and `sweep_inhibit`=0.
- R3: A trigger that arrives during SWEEP or HOLDOFF gives no `sweep_start` and is not remembered afterwards.
- R4: `sweep_end`=1 during SWEEP starts holdoff. `holdoff_active` and `sweep_inhibit` are then high for exactly `holdoff_len`+1 cycles, beginning the cycle after the pulse. `ready` returns the cycle after that.
- R5: `lockout_in`=1 raises `sweep_inhibit` and blocks `ready` and `sweep_start` in the same cycle. Holdoff is held while lockout stays high and then lasts `holdoff_len`+1 cycles after the last lockout cycle.
- R6: Mode encodings are 0=normal, 1=auto, 2=single-shot and 3=normal. In auto mode, when ARMED cycle index `auto_len` is reached with no trigger (indices count from 0 at the first ARMED cycle), `sweep_start` and `auto_req` rise together in that cycle.
- R7: In auto mode a trigger starts the sweep with `auto_req`=0. The quiet-period count restarts from 0 each time the controller re-arms.
- R8: In normal mode, `sweep_start` and `auto_req` stay 0 for as long as no trigger arrives.
- R9: In single-shot mode, after one sweep and its holdoff the controller is LOCKED: `ready`=0, `sweep_inhibit`=1, and triggers produce no start.
- R10: `arm_reset`=1 while LOCKED moves the controller to ARMED in the next cycle, and the next trigger is then accepted.
- R11: A change of `mode_sel` blocks starts in that cycle and aborts any holdoff. The next cycle is ARMED, or LOCKED if the new mode is single-shot.
- R12: The holdoff length is taken from `holdoff_len` when holdoff is loaded, so different values give different interval lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Run mode: 0 normal, 1 auto, 2 single-shot, 3 normal |
| trig_in | input | 1 | One-cycle trigger pulse |
| sweep_end | input | 1 | One-cycle end-of-ramp pulse |
| lockout_in | input | 1 | External sweep lockout level from the host |
| arm_reset | input | 1 | Single-shot re-arm, already debounced |
| holdoff_len | input | HOLD_W | Holdoff length in cycles, minus one |
| auto_len | input | AUTO_W | Auto quiet period in ARMED cycles |
| sweep_start | output | 1 | Request to start the ramp in this cycle |
| sweep_inhibit | output | 1 | Sweep disabled (lockout, holdoff or locked) |
| holdoff_active | output | 1 | High while holdoff is in progress |
| ready | output | 1 | Armed and able to accept a trigger |
| auto_req | output | 1 | Free-run start caused by the auto timeout |

## Verification
The assertions assume three things about the inputs. `trig_in`, `sweep_end` and `arm_reset` are synchronous pulses or levels that are already debounced. `sweep_end` arrives only while a sweep is running. `mode_sel` changes only between whole scenarios. The directed stimulus respects all three. It drives every input just after a rising edge and raises `sweep_end` only after it has seen a start. Each holdoff and auto-timeout length is measured by counting cycles at the ports, and each count is compared with the value the requirements predict.

// File: rtl/sweep_ctl_pkg.sv
package sweep_ctl_pkg;

    localparam logic [1:0] MODE_NORMAL = 2'd0;
    localparam logic [1:0] MODE_AUTO   = 2'd1;
    localparam logic [1:0] MODE_SINGLE = 2'd2;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_SWEEP   = 2'd1,
        ST_HOLDOFF = 2'd2,
        ST_LOCKED  = 2'd3
    } sweep_state_e;

endpackage

// File: rtl/sweep_hold_timer.sv
module sweep_hold_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (load)       cnt <= len;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R12: the loaded length is the value presented at load time
    a_r12_load_takes_len: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (cnt == $past(len)));

    // R4: the count never rises without a load
    a_r4_count_down_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr && !$past(!rst_n)) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/sweep_auto_timer.sv
module sweep_auto_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt != len) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == len);

    // R7: any idle interruption restarts the quiet period
    a_r7_restart_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/sweep_mode_ctrl.sv
module sweep_mode_ctrl
    import sweep_ctl_pkg::*;
#(
    parameter int HOLD_W = 8,
    parameter int AUTO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              trig_in,
    input  logic              sweep_end,
    input  logic              lockout_in,
    input  logic              arm_reset,
    input  logic [HOLD_W-1:0] holdoff_len,
    input  logic [AUTO_W-1:0] auto_len,
    output logic              sweep_start,
    output logic              sweep_inhibit,
    output logic              holdoff_active,
    output logic              ready,
    output logic              auto_req
);
    sweep_state_e state, state_nx;
    logic [1:0]   mode_q;
    logic         shot_taken;
    logic         mode_chg;
    logic         is_auto, is_single;
    logic         hold_zero, hold_load;
    logic         auto_run, auto_expired, auto_fire;

    assign mode_chg  = (mode_sel != mode_q);
    assign is_auto   = (mode_q == MODE_AUTO);
    assign is_single = (mode_q == MODE_SINGLE);

    // holdoff counter: reloaded while lockout persists or at end of sweep
    assign hold_load = lockout_in || ((state == ST_SWEEP) && sweep_end);

    sweep_hold_timer #(.W(HOLD_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mode_chg),
        .load  (hold_load),
        .len   (holdoff_len),
        .zero  (hold_zero)
    );

    // auto quiet-period counter: runs only while armed in auto mode
    assign auto_run = (state == ST_ARMED) && is_auto && !mode_chg
                      && !trig_in && !lockout_in;

    sweep_auto_timer #(.W(AUTO_W)) u_auto (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (auto_run),
        .len     (auto_len),
        .expired (auto_expired)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_ARMED;
            mode_q     <= MODE_NORMAL;
            shot_taken <= 1'b0;
        end else begin
            state  <= state_nx;
            mode_q <= mode_sel;
            if (mode_chg)
                shot_taken <= (mode_sel == MODE_SINGLE);
            else if (arm_reset)
                shot_taken <= 1'b0;
            else if (sweep_start && is_single)
                shot_taken <= 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (mode_chg) begin
            state_nx = (mode_sel == MODE_SINGLE) ? ST_LOCKED : ST_ARMED;
        end else begin
            unique case (state)
                ST_ARMED: begin
                    if (lockout_in)       state_nx = ST_HOLDOFF;
                    else if (sweep_start) state_nx = ST_SWEEP;
                end
                ST_SWEEP: begin
                    if (lockout_in || sweep_end) state_nx = ST_HOLDOFF;
                end
                ST_HOLDOFF: begin
                    if (!lockout_in && hold_zero)
                        state_nx = (is_single && shot_taken && !arm_reset)
                                   ? ST_LOCKED : ST_ARMED;
                end
                ST_LOCKED: begin
                    if (lockout_in)     state_nx = ST_HOLDOFF;
                    else if (arm_reset) state_nx = ST_ARMED;
                end
                default: state_nx = ST_ARMED;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready          = (state == ST_ARMED) && !lockout_in && !mode_chg;
        auto_fire      = ready && is_auto && auto_expired;
        sweep_start    = ready && (trig_in || auto_fire);
        auto_req       = auto_fire && !trig_in;
        holdoff_active = (state == ST_HOLDOFF);
        sweep_inhibit  = lockout_in || (state == ST_HOLDOFF) || (state == ST_LOCKED);
    end

    // R2: an accepted start always leads into a running sweep
    a_r2_start_enters_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_start |=> (state == ST_SWEEP));

    // R3: no start while busy
    a_r3_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SWEEP) || (state == ST_HOLDOFF)) |-> !sweep_start);

    // R4: holdoff implies inhibit, and holdoff is held until the count is zero
    a_r4_holdoff_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        holdoff_active |-> sweep_inhibit);
    a_r4_holdoff_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HOLDOFF) && !hold_zero && !mode_chg) |=> (state == ST_HOLDOFF));

    // R5: lockout blocks at once and leads into holdoff
    a_r5_lockout_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        lockout_in |-> (sweep_inhibit && !ready && !sweep_start));
    a_r5_lockout_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout_in && !mode_chg) |=> holdoff_active);

    // R6: free-run request only in auto mode, always with a start
    a_r6_auto_only_auto: assert property (@(posedge clk) disable iff (!rst_n)
        auto_req |-> (sweep_start && is_auto));

    // R9: locked stays locked without re-arm, lockout or mode change
    a_r9_locked_stays: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LOCKED) && !arm_reset && !lockout_in && !mode_chg)
        |=> (state == ST_LOCKED));

    // R11: a mode change blocks a start in its cycle
    a_r11_change_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> !sweep_start);
endmodule

// File: tb/sweep_mode_ctrl_test.sv
module sweep_mode_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 8;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode_sel;
    logic          trig_in, sweep_end, lockout_in, arm_reset;
    logic [HW-1:0] holdoff_len;
    logic [AW-1:0] auto_len;
    logic          sweep_start, sweep_inhibit, holdoff_active, ready, auto_req;

    int checks = 0;
    int errors = 0;

    sweep_mode_ctrl #(.HOLD_W(HW), .AUTO_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .trig_in(trig_in),
        .sweep_end(sweep_end), .lockout_in(lockout_in), .arm_reset(arm_reset),
        .holdoff_len(holdoff_len), .auto_len(auto_len),
        .sweep_start(sweep_start), .sweep_inhibit(sweep_inhibit),
        .holdoff_active(holdoff_active), .ready(ready), .auto_req(auto_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #2;
    endtask

    task automatic measure_holdoff(input int exp_cycles, input string req);
        int n = 0;
        for (int i = 0; i < 400; i++) begin
            #1;
            if (!holdoff_active) break;
            n++;
            if (sweep_inhibit !== 1'b1) check_eq(req, "inhibit during holdoff", sweep_inhibit, 1);
            next_cycle();
        end
        check_eq(req, "holdoff length", n, exp_cycles);
    endtask

    // Starts a sweep by trigger, ends it, and measures the holdoff.
    task automatic sweep_cycle(input int hl, input string req);
        holdoff_len = hl[HW-1:0];
        trig_in = 1'b1; #1;
        check_eq("R2", "start on trigger", sweep_start, 1);
        next_cycle(); trig_in = 1'b0;
        sweep_end = 1'b1; next_cycle(); sweep_end = 1'b0;
        measure_holdoff(hl + 1, req);
    endtask

    task automatic t_reset();
        #1;
        check_eq("R1", "ready", ready, 1);
        check_eq("R1", "inhibit", sweep_inhibit, 0);
        check_eq("R1", "holdoff", holdoff_active, 0);
        check_eq("R1", "start", sweep_start, 0);
        check_eq("R1", "auto", auto_req, 0);
    endtask

    task automatic t_normal();
        int starts = 0;
        for (int i = 0; i < 40; i++) begin
            #1;
            if (sweep_start || auto_req) starts++;
            next_cycle();
        end
        check_eq("R8", "idle starts in normal", starts, 0);
        holdoff_len = 8'd3;
        trig_in = 1'b1; #1;
        check_eq("R2", "start pulse", sweep_start, 1);
        check_eq("R2", "no auto_req", auto_req, 0);
        next_cycle();
        #1;
        check_eq("R3", "trigger in sweep ignored", sweep_start, 0);
        check_eq("R2", "ready low in sweep", ready, 0);
        check_eq("R2", "inhibit low in sweep", sweep_inhibit, 0);
        trig_in = 1'b0;
        next_cycle();
        sweep_end = 1'b1; #1;
        next_cycle(); sweep_end = 1'b0;
        trig_in = 1'b1; #1;
        check_eq("R3", "trigger in holdoff ignored", sweep_start, 0);
        trig_in = 1'b0;
        measure_holdoff(4, "R4");
        check_eq("R4", "ready after holdoff", ready, 1);
        check_eq("R3", "dropped trigger not queued", sweep_start, 0);
        sweep_cycle(7, "R12");
        check_eq("R12", "ready after long holdoff", ready, 1);
    endtask

    task automatic t_lockout();
        holdoff_len = 8'd2;
        lockout_in = 1'b1; trig_in = 1'b1; #1;
        check_eq("R5", "inhibit on lockout", sweep_inhibit, 1);
        check_eq("R5", "ready blocked", ready, 0);
        check_eq("R5", "start blocked", sweep_start, 0);
        trig_in = 1'b0;
        for (int i = 0; i < 3; i++) begin
            next_cycle(); #1;
            check_eq("R5", "holdoff held by lockout", holdoff_active, 1);
        end
        next_cycle(); lockout_in = 1'b0;
        measure_holdoff(3, "R5");
        check_eq("R5", "ready after lockout holdoff", ready, 1);
    endtask

    task automatic t_auto();
        int k = 0;
        auto_len = 16'd5;
        holdoff_len = 8'd1;
        mode_sel = 2'd1; #1;
        check_eq("R11", "no ready during mode change", ready, 0);
        next_cycle();
        for (int i = 0; i < 50; i++) begin
            #1;
            if (sweep_start) break;
            k++;
            next_cycle();
        end
        check_eq("R6", "auto fire index", k, 5);
        check_eq("R6", "auto_req with start", auto_req, 1);
        next_cycle();
        sweep_end = 1'b1; next_cycle(); sweep_end = 1'b0;
        measure_holdoff(2, "R4");
        next_cycle(); next_cycle();
        trig_in = 1'b1; #1;
        check_eq("R7", "trigger starts in auto", sweep_start, 1);
        check_eq("R7", "auto_req low on trigger", auto_req, 0);
        next_cycle(); trig_in = 1'b0;
        sweep_end = 1'b1; next_cycle(); sweep_end = 1'b0;
        measure_holdoff(2, "R7");
        k = 0;
        for (int i = 0; i < 50; i++) begin
            #1;
            if (sweep_start) break;
            k++;
            next_cycle();
        end
        check_eq("R7", "timer restarted on re-arm", k, 5);
        next_cycle();
        sweep_end = 1'b1; next_cycle(); sweep_end = 1'b0;
        measure_holdoff(2, "R7");
    endtask

    task automatic t_single();
        int starts = 0;
        holdoff_len = 8'd2;
        mode_sel = 2'd2; next_cycle(); #1;
        check_eq("R11", "single entry locked ready", ready, 0);
        check_eq("R11", "single entry inhibit", sweep_inhibit, 1);
        trig_in = 1'b1; #1;
        check_eq("R9", "trigger while locked", sweep_start, 0);
        trig_in = 1'b0;
        arm_reset = 1'b1; next_cycle(); arm_reset = 1'b0; #1;
        check_eq("R10", "ready after re-arm", ready, 1);
        sweep_cycle(2, "R4");
        for (int i = 0; i < 10; i++) begin
            trig_in = 1'b1; #1;
            if (sweep_start) starts++;
            if (i == 0) begin
                check_eq("R9", "locked ready", ready, 0);
                check_eq("R9", "locked inhibit", sweep_inhibit, 1);
            end
            next_cycle();
        end
        trig_in = 1'b0;
        check_eq("R9", "starts while locked", starts, 0);
        arm_reset = 1'b1; next_cycle(); arm_reset = 1'b0;
        trig_in = 1'b1; #1;
        check_eq("R10", "trigger accepted after re-arm", sweep_start, 1);
        next_cycle(); trig_in = 1'b0;
        sweep_end = 1'b1; next_cycle(); sweep_end = 1'b0;
        measure_holdoff(3, "R9");
    endtask

    task automatic t_mode_change();
        holdoff_len = 8'd50;
        mode_sel = 2'd3; next_cycle(); #1;
        check_eq("R11", "code 3 arms as normal", ready, 1);
        lockout_in = 1'b1; next_cycle(); lockout_in = 1'b0;
        for (int i = 0; i < 5; i++) next_cycle();
        #1;
        check_eq("R11", "holdoff before change", holdoff_active, 1);
        mode_sel = 2'd0; next_cycle(); #1;
        check_eq("R11", "holdoff aborted", holdoff_active, 0);
        check_eq("R11", "ready after change", ready, 1);
        check_eq("R11", "inhibit after change", sweep_inhibit, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_sel = 2'd0; trig_in = 1'b0; sweep_end = 1'b0;
        lockout_in = 1'b0; arm_reset = 1'b0; holdoff_len = 8'd3; auto_len = 16'd5;
        repeat (3) next_cycle();
        rst_n = 1'b1;
        next_cycle();
        t_reset();
        t_normal();
        t_lockout();
        t_auto();
        t_single();
        t_mode_change();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule